// File: doc/BRIEF.md
# Bit-Serial Non-Adjacent-Form Adder

This block adds two numbers one digit position per clock, least significant digit first, and streams the sum out in the same order. Each operand digit is a signed power-of-two digit from {-1, 0, +1}. The operands are in canonic (non-adjacent) form: between any two nonzero digits of an operand there is at least one zero. The sum digits it emits keep that form, so no two neighbouring output digits are both nonzero. The form is kept as the digits stream through, with no separate recoding pass over a stored word.

A mode input, sampled with the first digit of a word, lets the second operand arrive as a plain two's-complement bit stream. This suits the weight-update loop of a sign-error adaptive filter. There a stored canonic weight gets a binary step term added to it or subtracted from it, and the updated weight comes back in canonic form, ready for the shift-and-add multiply.

Inside, the two input digits and a small signed carry form ordinary binary sum bits. A second stage then recodes these bits into non-adjacent form, looking one bit ahead. After the last input digit, the block runs three more positions by itself so that the full N+2-digit sum comes out.

Top module: `csd_serial_adder`

## Requirements
- R1: Digits on `a_digit`, `b_digit` and `out_digit` use the 2-bit code {nonzero, sign}: 00 is 0, 10 is +1 and 11 is -1. `out_digit` never carries the code 01, and it reads 00 whenever `out_valid` is low.
- R2: A digit pair is taken on a clock where `in_valid` is high. A word begins on the cycle where both `start` and `in_valid` are high while the block is idle. Each operand has WORD_DIGITS digits, least significant first. Cycles with `in_valid` low consume no digit, and their digit inputs have no effect.
- R3: For each word the block asserts `out_valid` for exactly WORD_DIGITS+2 digits, least significant first. In signed-digit mode their value equals the sum of the two operand values.
- R4: Within a word, no two consecutive output digits are both nonzero.
- R5: When `tc_mode` is high on the start cycle, operand B is a two's-complement number. Its bit is carried on `b_digit[1]`, `b_digit[0]` is ignored, and bit WORD_DIGITS-1 has weight -2^(WORD_DIGITS-1). The output value equals A plus that number. `tc_mode` on later cycles of the word has no effect.
- R6: When digits arrive on consecutive cycles, output digit j is on the port two cycles after the cycle in which input digit j was presented. The WORD_DIGITS+2 output digits come on consecutive cycles, and the final ones need no `in_valid`.
- R7: An input code 01 on `a_digit` (either mode), or on `b_digit` in signed-digit mode, in an accepted digit is taken as zero. It raises `err` from the next cycle, and `err` stays high until the next accepted start, which clears it unless that start digit is itself illegal.
- R8: `start` is ignored while a word is in progress. `start`, `in_valid` and the digit inputs are ignored during the three closing positions, and none of them changes the result.
- R9: While `rst_n` is low on a clock edge (synchronous, active low), `out_valid` and `err` go low and `out_digit` goes to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Marks the first digit of a word, qualified by in_valid |
| in_valid | input | 1 | Digit pair on a_digit/b_digit is valid this cycle |
| tc_mode | input | 1 | Sampled at start: operand B is two's complement |
| a_digit | input | 2 | Operand A digit {nonzero, sign} |
| b_digit | input | 2 | Operand B digit {nonzero, sign}, or bit on [1] in two's-complement mode |
| out_digit | output | 2 | Sum digit {nonzero, sign} |
| out_valid | output | 1 | out_digit holds a sum digit |
| err | output | 1 | Sticky illegal-code flag for the current word |

## Verification
The bench builds the adder with WORD_DIGITS = 8. At that length the largest canonic operands (+-170) and the two's-complement extremes (-128 and +127) can be driven directly, so the widest carry chains and the top output digit are reached. The short word also lets a few hundred random words, with random idle gaps, pass through the start, load and flush ordering many times. Directed words cover the latency, illegal codes, a stray start in mid-word, and junk during the flush.

// File: rtl/csd_pkg.sv
// Package: shared digit codes and sequencer states for the serial
// non-adjacent-form adder. Assumes the 2-bit digit code {nonzero, sign}.
package csd_pkg;

    typedef logic [1:0] sd_code_t;

    localparam sd_code_t SD_ZERO = 2'b00;
    localparam sd_code_t SD_POS  = 2'b10;
    localparam sd_code_t SD_NEG  = 2'b11;
    localparam sd_code_t SD_BAD  = 2'b01;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_LOAD  = 2'd1,
        SEQ_FLUSH = 2'd2
    } seq_state_e;

endpackage

// File: rtl/csd_digit_decode.sv
// Module: turns one input digit code into a signed value in {-1,0,+1}.
// In binary mode the bit on code[1] is taken with weight +1, or -1 at the
// top position; code[0] is then ignored. In signed-digit mode the code 01
// is flagged as illegal and taken as zero. Assumes use_digit is low on
// cycles where no digit is consumed, which forces the value to zero.
module csd_digit_decode
    import csd_pkg::*;
(
    input  logic              use_digit,
    input  logic              binary_mode,
    input  logic              top_weight,
    input  logic [1:0]        code,
    output logic signed [1:0] value,
    output logic              illegal
);

    // Decode the digit according to the active mode.
    always_comb begin
        value   = 2'sb00;
        illegal = 1'b0;
        if (use_digit) begin
            if (binary_mode) begin
                if (code[1]) begin
                    value = top_weight ? 2'sb11 : 2'sb01;
                end
            end else begin
                unique case (code)
                    SD_POS:  value = 2'sb01;
                    SD_NEG:  value = 2'sb11;
                    SD_BAD:  illegal = 1'b1;
                    default: value = 2'sb00;
                endcase
            end
        end
    end

endmodule

// File: rtl/csd_seq_ctrl.sv
// Module: word sequencer. It accepts a start with the first digit while
// idle, counts WORD_DIGITS accepted digits, then runs three positions on
// its own so the recoder can emit all WORD_DIGITS+2 sum digits.
// Assumes start is only meaningful together with in_valid.
module csd_seq_ctrl
    import csd_pkg::*;
#(
    parameter int WORD_DIGITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    input  logic tc_mode,
    output logic adv,
    output logic first,
    output logic feeding,
    output logic msb_now,
    output logic tc_eff
);

    localparam int POS_W = $clog2(WORD_DIGITS + 3);
    localparam logic [POS_W-1:0] POS_MSB = POS_W'(WORD_DIGITS - 1);
    localparam logic [POS_W-1:0] POS_END = POS_W'(WORD_DIGITS + 2);
    localparam logic [POS_W-1:0] POS_ONE = POS_W'(1);

    seq_state_e       state_q;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] cur_pos;
    logic             mode_q;
    logic             accept;

    // Decide whether this cycle moves the datapath by one position.
    always_comb begin
        accept  = (state_q == SEQ_IDLE) && start && in_valid;
        feeding = accept || ((state_q == SEQ_LOAD) && in_valid);
        adv     = feeding || (state_q == SEQ_FLUSH);
        first   = accept;
        cur_pos = accept ? '0 : pos_q;
        msb_now = feeding && (cur_pos == POS_MSB);
        tc_eff  = accept ? tc_mode : mode_q;
    end

    // Step the state, the position count and the sampled mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            pos_q   <= '0;
            mode_q  <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        state_q <= (WORD_DIGITS == 1) ? SEQ_FLUSH : SEQ_LOAD;
                    end
                end
                SEQ_LOAD: begin
                    if (in_valid && (pos_q == POS_MSB)) begin
                        state_q <= SEQ_FLUSH;
                    end
                end
                SEQ_FLUSH: begin
                    if (pos_q == POS_END) begin
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
            if (adv) begin
                pos_q <= ((state_q == SEQ_FLUSH) && (pos_q == POS_END)) ? '0 : cur_pos + POS_ONE;
            end
            if (accept) begin
                mode_q <= tc_mode;
            end
        end
    end

    // R2: the position count never leaves the span of one word.
    p_pos_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= POS_END);

endmodule

// File: rtl/csd_sum_stage.sv
// Module: serial binary sum stage. It adds two signed digits and a signed
// carry in {-2..1} and produces one two's-complement sum bit per position.
// The bit of the current position is given both combinationally (for the
// recoder's lookahead) and registered. Assumes the inputs are zero during
// the closing positions, so the carry settles to the sign of the sum.
module csd_sum_stage (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              first,
    input  logic              last_pos,
    input  logic signed [1:0] a_val,
    input  logic signed [1:0] b_val,
    output logic              bit_now,
    output logic              bit_q
);

    logic signed [1:0] carry_q;
    logic signed [1:0] carry_in;
    logic signed [1:0] carry_next;
    logic signed [2:0] total;

    // Form the position total and split it into sum bit and next carry.
    always_comb begin
        carry_in   = first ? 2'sb00 : carry_q;
        total      = {a_val[1], a_val} + {b_val[1], b_val} + {carry_in[1], carry_in};
        bit_now    = total[0];
        carry_next = total[2:1];
    end

    // Hold the carry and the last sum bit between positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 2'sb00;
            bit_q   <= 1'b0;
        end else if (adv) begin
            carry_q <= carry_next;
            bit_q   <= bit_now;
        end
    end

    // R3: at the final position the carry is a pure sign extension of the sum.
    p_final_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last_pos) |-> (carry_next == (bit_now ? 2'sb11 : 2'sb00)));

endmodule

// File: rtl/csd_recode_stage.sv
// Module: serial binary to non-adjacent-form recoder. For each position it
// takes the previous sum bit, a recoding carry and the next sum bit
// (one-bit lookahead) and emits one signed digit into an output register.
// Assumes the first position of a word only primes the pipeline.
module csd_recode_stage
    import csd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     adv,
    input  logic     first,
    input  logic     bit_prev,
    input  logic     bit_next,
    output sd_code_t out_code,
    output logic     out_valid
);

    logic     rc_q;
    logic     rc_in;
    logic     rc_next;
    logic     emit;
    logic     last_nz_q;
    logic [1:0] level;
    sd_code_t digit;

    // Choose the output digit and the next recoding carry.
    always_comb begin
        emit  = adv && !first;
        rc_in = first ? 1'b0 : rc_q;
        level = {1'b0, bit_prev} + {1'b0, rc_in};
        digit   = SD_ZERO;
        rc_next = 1'b0;
        unique case (level)
            2'd1: begin
                digit   = bit_next ? SD_NEG : SD_POS;
                rc_next = bit_next;
            end
            2'd2: rc_next = 1'b1;
            default: rc_next = 1'b0;
        endcase
    end

    // Register the digit, its valid flag and the recoding carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc_q      <= 1'b0;
            out_code  <= SD_ZERO;
            out_valid <= 1'b0;
        end else begin
            out_valid <= emit;
            out_code  <= emit ? digit : SD_ZERO;
            if (adv) begin
                rc_q <= first ? 1'b0 : rc_next;
            end
        end
    end

    // Remember whether the last emitted digit of this word was nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_nz_q <= 1'b0;
        end else if (adv && first) begin
            last_nz_q <= 1'b0;
        end else if (out_valid) begin
            last_nz_q <= out_code[1];
        end
    end

    // R1: the illegal code never leaves the recoder.
    p_out_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_code != SD_BAD);

    // R4: no two consecutive emitted digits are both nonzero.
    p_no_adjacent_nz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && last_nz_q) |-> !out_code[1]);

endmodule

// File: rtl/csd_serial_adder.sv
// Module: top of the bit-serial non-adjacent-form adder. Digits enter least
// significant first; the sum leaves in canonic form two cycles later.
// Operand B may be two's complement (mode sampled at start). Illegal codes
// are taken as zero and raise a sticky error flag for the word.
// Assumes operands in signed-digit mode are already canonic.
module csd_serial_adder
    import csd_pkg::*;
#(
    parameter int WORD_DIGITS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       in_valid,
    input  logic       tc_mode,
    input  logic [1:0] a_digit,
    input  logic [1:0] b_digit,
    output logic [1:0] out_digit,
    output logic       out_valid,
    output logic       err
);

    localparam int OPERANDS = 2;

    logic adv;
    logic first;
    logic feeding;
    logic msb_now;
    logic tc_eff;
    logic bit_now;
    logic bit_q;
    logic illegal_any;
    logic err_q;
    logic [WORD_DIGITS+2:0] end_mark;

    logic [1:0]        codes   [OPERANDS];
    logic signed [1:0] vals    [OPERANDS];
    logic [OPERANDS-1:0] illegal;

    assign codes[0] = a_digit;
    assign codes[1] = b_digit;

    csd_seq_ctrl #(
        .WORD_DIGITS(WORD_DIGITS)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .in_valid(in_valid),
        .tc_mode (tc_mode),
        .adv     (adv),
        .first   (first),
        .feeding (feeding),
        .msb_now (msb_now),
        .tc_eff  (tc_eff)
    );

    // One decoder per operand; only operand B may be switched to binary.
    for (genvar k = 0; k < OPERANDS; k++) begin : g_dec
        csd_digit_decode i_dec (
            .use_digit  (feeding),
            .binary_mode((k == OPERANDS - 1) && tc_eff),
            .top_weight (msb_now),
            .code       (codes[k]),
            .value      (vals[k]),
            .illegal    (illegal[k])
        );
    end

    // Shift a marker along the positions of a word to find the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_mark <= '0;
        end else if (adv) begin
            end_mark <= first ? {{(WORD_DIGITS+2){1'b0}}, 1'b1} : {end_mark[WORD_DIGITS+1:0], 1'b0};
        end
    end

    csd_sum_stage i_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .first   (first),
        .last_pos(end_mark[WORD_DIGITS+1]),
        .a_val   (vals[0]),
        .b_val   (vals[1]),
        .bit_now (bit_now),
        .bit_q   (bit_q)
    );

    csd_recode_stage i_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .first    (first),
        .bit_prev (bit_q),
        .bit_next (bit_now),
        .out_code (out_digit),
        .out_valid(out_valid)
    );

    // Flag any illegal accepted code; a new word starts a fresh flag.
    always_comb illegal_any = |illegal;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (first) begin
            err_q <= illegal_any;
        end else if (illegal_any) begin
            err_q <= 1'b1;
        end
    end

    assign err = err_q;

    // R7: the error flag holds until the next accepted start.
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !first) |=> err_q);

    // R2: a sum digit only follows a cycle in which the word advanced.
    p_out_paced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(adv));

    // R1: no sum digit is shown while out_valid is low.
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_digit == SD_ZERO));

endmodule

// File: tb/test_csd_serial_adder.sv
// Bench: fixed-seed random and directed words against bench-side models.
module test_csd_serial_adder;

    localparam int N    = 8;
    localparam int OUTN = N + 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       in_valid = 1'b0;
    logic       tc_mode = 1'b0;
    logic [1:0] a_digit = 2'b00;
    logic [1:0] b_digit = 2'b00;
    logic [1:0] out_digit;
    logic       out_valid;
    logic       err;

    int checks = 0;
    int fails  = 0;
    int pc     = 0;

    int         ncap;
    logic [1:0] cap [0:15];
    int         first_cyc;
    int         last_cyc;
    int         adj_bad;
    logic       prev_nz;

    always #4 clk = ~clk;

    csd_serial_adder #(.WORD_DIGITS(N)) i_csd_serial_adder (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .tc_mode(tc_mode), .a_digit(a_digit), .b_digit(b_digit),
        .out_digit(out_digit), .out_valid(out_valid), .err(err)
    );

    always @(posedge clk) pc <= pc + 1;

    // Output monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (out_valid) begin
            if (ncap < 16) cap[ncap] = out_digit;
            if (ncap == 0) first_cyc = pc;
            last_cyc = pc;
            if ((prev_nz && out_digit[1]) || out_digit == 2'b01) adj_bad++;
            prev_nz = out_digit[1];
            ncap++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dval(input logic [1:0] c);
        if (c == 2'b10) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    // Canonic (non-adjacent) form of x in N digits, code {nonzero, sign}.
    function automatic logic [2*N-1:0] naf_of(input int x);
        logic [2*N-1:0] r = '0;
        int v = x;
        for (int i = 0; i < N; i++) begin
            if ((v & 1) != 0) begin
                if ((v & 3) == 1) begin
                    r[2*i +: 2] = 2'b10;
                    v = v - 1;
                end else begin
                    r[2*i +: 2] = 2'b11;
                    v = v + 1;
                end
            end
            v = v >>> 1;
        end
        return r;
    endfunction

    task automatic run_word(input bit mode, input int av, input int bv, input int gap_pct,
                            input int bad_pos, input bit mid_start, input bit flush_junk);
        logic [2*N-1:0] ac = naf_of(av);
        logic [2*N-1:0] bc = naf_of(bv);
        logic [N-1:0]   bb = bv[N-1:0];
        int t0 = 0;
        int sum = 0;
        int expv;
        ncap = 0; prev_nz = 1'b0; adj_bad = 0;
        for (int i = 0; i < N; i++) begin
            if (i > 0) begin
                while ($urandom_range(99) < gap_pct) begin
                    @(negedge clk);
                    start = 1'b0; in_valid = 1'b0;
                    a_digit = 2'($urandom); b_digit = 2'($urandom);
                end
            end
            @(negedge clk);
            if (i == 0) t0 = pc;
            start    = (i == 0) || (mid_start && i == 3);
            in_valid = 1'b1;
            tc_mode  = (i == 0) ? mode : !mode;
            a_digit  = (i == bad_pos) ? 2'b01 : ac[2*i +: 2];
            b_digit  = mode ? {bb[i], 1'($urandom)} : bc[2*i +: 2];
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            start = flush_junk; in_valid = flush_junk;
            a_digit = 2'($urandom); b_digit = 2'($urandom);
        end
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < OUTN && i < ncap; i++) sum += dval(cap[i]) * (1 << i);
        expv = av + bv;
        if (bad_pos >= 0) expv -= dval(ac[2*bad_pos +: 2]) * (1 << bad_pos);
        chk(ncap == OUTN, flush_junk ? "R8 digit count" : "R3 digit count", ncap, OUTN);
        chk(sum == expv, mode ? "R5 sum value" : (mid_start ? "R8 sum value" : "R3 sum value"), sum, expv);
        chk(adj_bad == 0, "R4 adjacent nonzero or code 01", adj_bad, 0);
        chk(err == (bad_pos >= 0), "R7 error flag", int'(err), int'(bad_pos >= 0));
        if (gap_pct == 0) begin
            chk(first_cyc - t0 == 2, "R6 first digit latency", first_cyc - t0, 2);
            chk(last_cyc - first_cyc == OUTN - 1, "R6 contiguous output", last_cyc - first_cyc, OUTN - 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", pc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        process::self().srandom(32'h5EED_2024);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
        chk(err == 1'b0, "R9 err in reset", int'(err), 0);
        chk(out_digit == 2'b00, "R9 out_digit in reset", int'(out_digit), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R2 no output without a start", int'(out_valid), 0);

        // Directed corners: extremes, cancellation, binary step operand.
        run_word(1'b0, 170, 170, 0, -1, 1'b0, 1'b0);
        run_word(1'b0, -170, -170, 0, -1, 1'b0, 1'b0);
        run_word(1'b0, 170, -170, 0, -1, 1'b0, 1'b0);
        run_word(1'b0, 0, 0, 0, -1, 1'b0, 1'b0);
        run_word(1'b1, 170, 127, 0, -1, 1'b0, 1'b0);
        run_word(1'b1, -170, -128, 0, -1, 1'b0, 1'b0);
        run_word(1'b1, 0, -1, 0, -1, 1'b0, 1'b0);
        // R7: illegal code, then a clean word clears the flag.
        run_word(1'b0, 85, -42, 0, 2, 1'b0, 1'b0);
        run_word(1'b0, 85, -42, 0, -1, 1'b0, 1'b0);
        run_word(1'b1, -21, 100, 0, 0, 1'b0, 1'b0);
        // R8: stray start mid-word and junk during the closing positions.
        run_word(1'b0, 101, -77, 0, -1, 1'b1, 1'b1);
        run_word(1'b1, -99, -64, 30, -1, 1'b1, 1'b1);

        // Random words with idle gaps (R2) in both modes.
        for (int w = 0; w < 300; w++) begin
            bit m = w[0];
            int av = int'($urandom_range(340)) - 170;
            int bv = m ? int'($urandom_range(255)) - 128 : int'($urandom_range(340)) - 170;
            run_word(m, av, bv, 20, -1, 1'b0, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule